// File: doc/BRIEF.md
# Class-Sorting Block Packer for Three-Level Cell Storage

This block turns a 64-bit write word into an 81-bit stored word for a memory whose cells hold three levels. Each cell holds one ternary digit, and each digit is written as a 2-bit pair with values 00, 01 or 10. The pair 11 is never produced. The word is cut into eight bytes, and all eight are classified and encoded side by side. A byte with fewer than three `11` pairs is a common byte. Common bytes cover 243 patterns and fit exactly into five ternary digits. The other 13 patterns are rare bytes.

A rare byte's code spends the spare code space on two items. The first is where the byte came from in the input word. The second is the class of the code placed directly after it. The packer puts all rare codes first and all common codes after them. It then adds one flag bit that says whether any rare code is present. A reader can rebuild the original block order from the stored word alone.

The datapath is a four-register pipeline with a valid/ready input and a valid output. It accepts one word every clock once reset is released.

Top module: `clus_reorder_packer`

## Requirements
- R1: Input block i (i = 0..7) is `in_data_i[63-8i -: 8]`. Its digit pairs are bits [7:6], [5:4], [3:2] and [1:0]. A block is rare when at least three of its pairs equal `11`; otherwise it is common.
- R2: A common block with no `11` pair is coded as `{2'b00, block}`.
- R3: A common block with one `11` pair uses value v = 81 + 27·p + t. Here p is the index of the `11` pair (3 = bits [7:6], 0 = bits [1:0]), and t is the other three pairs read from the highest pair down as a base-3 number. A common block with two `11` pairs uses v = 189 + 9·k + t. Here k numbers the pair positions in the order (3,2)=0, (3,1)=1, (3,0)=2, (2,1)=3, (2,0)=4, (1,0)=5. The code is v written as five base-3 digits, with the most significant digit in code bits [9:8].
- R4: A rare block uses value v = 2·(8·r + i) + n and the same five-digit form. Here i is its input index and n is its next-class flag. r = 12 when all four pairs are `11`. Otherwise r = 3·q + d, where q is the index of the single non-`11` pair and d is that pair's value.
- R5: The stored word holds all rare codes first and then all common codes. Each group keeps its input order, so a word with a single class is not permuted.
- R6: A rare code's next-class flag is 1 when the code after it is rare. For the last rare code it is 0, except when all eight blocks are rare; then it is 1.
- R7: Output bit 80 is 1 when any block is rare and 0 otherwise.
- R8: Output slot s (s = 0..7) occupies bits `[79-10s -: 10]`.
- R9: A word accepted on a clock edge appears with `out_valid_o` high after the fourth edge, counting the accepting edge. Words may arrive on consecutive clocks. `out_valid_o` is low whenever no word was accepted four edges earlier.
- R10: No 2-bit digit in bits [79:0] of a valid output equals `11`.
- R11: While reset is asserted, `in_ready_o` and `out_valid_o` are low. `in_ready_o` goes high on the first edge after reset is released and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Packer can take a word |
| in_data_i | input | 64 | Write word |
| out_valid_o | output | 1 | Stored word present |
| out_data_o | output | 81 | Flag bit plus eight sorted 10-bit codes |

## Verification
The bench builds the packer with its default parameters: eight blocks of eight bits and ten-bit codes. With these values, each of the 256 byte patterns can appear in every input position. Directed words cover each encoding branch, including the boundary between two and three `11` pairs. They also cover all-rare and all-common words, a single trailing rare block, and interleaved classes. A long run of back-to-back pseudo-random words, biased toward `11` pairs, checks that the ordering, flags and per-word latency hold under full throughput.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

  typedef logic [7:0] blk_t;
  typedef logic [9:0] code_t;

  // rare: three or more 11 pairs
  function automatic logic is_rare(input blk_t b);
    int n;
    n = 0;
    for (int j = 0; j < 4; j++) if (b[2*j+:2] == 2'b11) n++;
    return n >= 3;
  endfunction

  function automatic code_t tern5(input logic [7:0] v);
    logic [7:0] x;
    code_t r;
    x = v;
    r = '0;
    for (int j = 0; j < 5; j++) begin
      r[2*j+:2] = 2'(x % 8'd3);
      x = x / 8'd3;
    end
    return r;
  endfunction

endpackage

// File: rtl/pkr_byte_enc.sv
module pkr_byte_enc
  import pkr_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  blk_t             blk_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             nxt_i,
  output code_t            code_o
);

  int n3, t, p, q, pk, cnt, r, v;

  always_comb begin
    n3 = 0; t = 0; p = 0; q = 0; pk = 0; cnt = 0; r = 0; v = 0;
    for (int j = 3; j >= 0; j--) begin
      if (blk_i[2*j+:2] == 2'b11) begin
        n3++;
        p = j;
      end else begin
        t = t * 3 + int'(blk_i[2*j+:2]);
        q = j;
      end
    end
    for (int hi = 3; hi >= 1; hi--) begin
      for (int lo = hi - 1; lo >= 0; lo--) begin
        if (blk_i[2*hi+:2] == 2'b11 && blk_i[2*lo+:2] == 2'b11) pk = cnt;
        cnt++;
      end
    end
    case (n3)
      0: v = t;
      1: v = 81 + 27 * p + t;
      2: v = 189 + 9 * pk + t;
      default: begin
        r = (n3 == 4) ? 12 : 3 * q + t;
        v = 2 * (r * (1 << POS_W) + int'(pos_i)) + int'(nxt_i);
      end
    endcase
    code_o = tern5(8'(v));
  end

endmodule

// File: rtl/pkr_slot_calc.sv
module pkr_slot_calc #(
  parameter  int NUM_BLK = 8,
  localparam int SLOT_W  = $clog2(NUM_BLK),
  localparam int CNT_W   = $clog2(NUM_BLK + 1)
) (
  input  logic [NUM_BLK-1:0]             rare_i,
  output logic [NUM_BLK-1:0][SLOT_W-1:0] slot_o,
  output logic [NUM_BLK-1:0]             nxt_o
);

  logic [CNT_W-1:0] n1, c1, c0;

  // stable partition: rare blocks first
  always_comb begin
    n1 = '0;
    for (int i = 0; i < NUM_BLK; i++) n1 = n1 + CNT_W'(rare_i[i]);
    c1 = '0;
    c0 = '0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (rare_i[i]) begin
        slot_o[i] = SLOT_W'(c1);
        nxt_o[i]  = (c1 + CNT_W'(1) != n1) || (n1 == CNT_W'(NUM_BLK));
        c1 = c1 + CNT_W'(1);
      end else begin
        slot_o[i] = SLOT_W'(n1 + c0);
        nxt_o[i]  = 1'b0;
        c0 = c0 + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pkr_slot_mux.sv
module pkr_slot_mux #(
  parameter  int NUM_BLK = 8,
  parameter  int CODE_W  = 10,
  localparam int SLOT_W  = $clog2(NUM_BLK),
  localparam int PCK_W   = NUM_BLK * CODE_W
) (
  input  logic [NUM_BLK-1:0][CODE_W-1:0] code_i,
  input  logic [NUM_BLK-1:0][SLOT_W-1:0] slot_i,
  output logic [PCK_W-1:0]               pack_o
);

  for (genvar s = 0; s < NUM_BLK; s++) begin : g_slot
    logic [CODE_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_BLK; i++)
        if (slot_i[i] == SLOT_W'(s)) acc = acc | code_i[i];
    end
    assign pack_o[PCK_W-1-s*CODE_W -: CODE_W] = acc;
  end

endmodule

// File: rtl/clus_reorder_packer.sv
module clus_reorder_packer
  import pkr_pkg::*;
#(
  parameter  int NUM_BLK = 8,
  parameter  int BLK_W   = 8,
  parameter  int CODE_W  = 10,
  localparam int DATA_W  = NUM_BLK * BLK_W,
  localparam int PCK_W   = NUM_BLK * CODE_W,
  localparam int OUT_W   = PCK_W + 1,
  localparam int SLOT_W  = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o
);

  logic rdy_q, v1_q, v2_q, v3_q, ov_q, aux3_q;
  logic [DATA_W-1:0] d1_q, d2_q;
  logic [NUM_BLK-1:0] rare1, rare2_q, nxt2, nxt2_q;
  logic [NUM_BLK-1:0][SLOT_W-1:0] slot2, slot2_q, slot3_q;
  logic [NUM_BLK-1:0][CODE_W-1:0] code3, code3_q;
  logic [PCK_W-1:0] pack4;
  logic [OUT_W-1:0] out_q;

  assign in_ready_o = rdy_q;

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    assign rare1[i] = is_rare(d1_q[DATA_W-1-i*BLK_W -: BLK_W]);

    pkr_byte_enc #(.POS_W(SLOT_W)) u_enc (
      .blk_i  (d2_q[DATA_W-1-i*BLK_W -: BLK_W]),
      .pos_i  (SLOT_W'(i)),
      .nxt_i  (nxt2_q[i]),
      .code_o (code3[i])
    );
  end

  pkr_slot_calc #(.NUM_BLK(NUM_BLK)) u_calc (
    .rare_i (rare1),
    .slot_o (slot2),
    .nxt_o  (nxt2)
  );

  pkr_slot_mux #(.NUM_BLK(NUM_BLK), .CODE_W(CODE_W)) u_mux (
    .code_i (code3_q),
    .slot_i (slot3_q),
    .pack_o (pack4)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      v3_q    <= 1'b0;
      ov_q    <= 1'b0;
      d1_q    <= '0;
      d2_q    <= '0;
      rare2_q <= '0;
      slot2_q <= '0;
      nxt2_q  <= '0;
      slot3_q <= '0;
      code3_q <= '0;
      aux3_q  <= 1'b0;
      out_q   <= '0;
    end else begin
      rdy_q   <= 1'b1;
      // s1: capture
      v1_q    <= in_valid_i & rdy_q;
      d1_q    <= in_data_i;
      // s2: classify and place
      v2_q    <= v1_q;
      d2_q    <= d1_q;
      rare2_q <= rare1;
      slot2_q <= slot2;
      nxt2_q  <= nxt2;
      // s3: encode
      v3_q    <= v2_q;
      code3_q <= code3;
      slot3_q <= slot2_q;
      aux3_q  <= |rare2_q;
      // s4: pack
      ov_q    <= v3_q;
      out_q   <= {aux3_q, pack4};
    end
  end

  assign out_valid_o = ov_q;
  assign out_data_o  = out_q;

endmodule

// File: rtl/pkr_checker.sv
module pkr_checker
  import pkr_pkg::*;
#(
  parameter  int NUM_BLK = 8,
  parameter  int BLK_W   = 8,
  parameter  int CODE_W  = 10,
  localparam int DATA_W  = NUM_BLK * BLK_W,
  localparam int PCK_W   = NUM_BLK * CODE_W,
  localparam int OUT_W   = PCK_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [OUT_W-1:0]  out_data_o
);

  logic [3:0][DATA_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[2:0], in_data_i};
  end

  function automatic logic any_rare(input logic [DATA_W-1:0] w);
    logic a;
    a = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) a = a | is_rare(w[DATA_W-1-i*BLK_W -: BLK_W]);
    return a;
  endfunction

  function automatic logic has_dig3(input logic [PCK_W-1:0] p);
    logic a;
    a = 1'b0;
    for (int j = 0; j < PCK_W / 2; j++) a = a | (p[2*j+:2] == 2'b11);
    return a;
  endfunction

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> ##4 out_valid_o);

  assert_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> in_ready_o);

  assert_no_dig3_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !has_dig3(out_data_o[PCK_W-1:0]));

  assert_aux_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o[OUT_W-1] == any_rare(hist_q[3]));

  for (genvar j = 0; j < NUM_BLK; j++) begin : g_plain
    logic [BLK_W-1:0] b;
    logic             clean;
    assign b     = hist_q[3][DATA_W-1-j*BLK_W -: BLK_W];
    assign clean = (b[7:6] != 2'b11) && (b[5:4] != 2'b11) && (b[3:2] != 2'b11) && (b[1:0] != 2'b11);
    assert_plain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_data_o[OUT_W-1] && clean) |->
        out_data_o[PCK_W-1-j*CODE_W -: CODE_W] == {2'b00, b});
  end

endmodule

bind clus_reorder_packer pkr_checker #(
  .NUM_BLK (NUM_BLK),
  .BLK_W   (BLK_W),
  .CODE_W  (CODE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/clus_reorder_packer_tb_top.sv
module clus_reorder_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [80:0] out_data;

  int checks = 0;
  int fails = 0;
  int pcnt = 0;
  bit done = 0;

  logic [80:0] exp_q[$];
  string       tag_q[$];
  int          stamp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) pcnt <= pcnt + 1;

  clus_reorder_packer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  function automatic logic [9:0] m_tern(int v);
    logic [9:0] c;
    int x;
    x = v;
    for (int j = 0; j < 5; j++) begin
      c[2*j+:2] = 2'(x % 3);
      x = x / 3;
    end
    return c;
  endfunction

  function automatic int m_n3(logic [7:0] b);
    int n;
    n = 0;
    for (int j = 0; j < 4; j++) if (b[2*j+:2] == 2'b11) n++;
    return n;
  endfunction

  function automatic logic [9:0] m_enc(logic [7:0] b, int pos, bit nx);
    int d[4];
    int n, t, p, q, k, v, r;
    int pairs_hi[6] = '{3, 3, 3, 2, 2, 1};
    int pairs_lo[6] = '{2, 1, 0, 1, 0, 0};
    for (int j = 0; j < 4; j++) d[j] = int'(b[2*j+:2]);
    n = m_n3(b);
    t = 0; p = 0; q = 0; k = 0;
    for (int j = 3; j >= 0; j--) begin
      if (d[j] == 3) p = j;
      else begin
        t = 3 * t + d[j];
        q = j;
      end
    end
    for (int m = 0; m < 6; m++)
      if (d[pairs_hi[m]] == 3 && d[pairs_lo[m]] == 3) k = m;
    if (n == 0)      v = t;
    else if (n == 1) v = 81 + 27 * p + t;
    else if (n == 2) v = 189 + 9 * k + t;
    else begin
      r = (n == 4) ? 12 : 3 * q + d[q];
      v = 2 * (8 * r + pos) + int'(nx);
    end
    return m_tern(v);
  endfunction

  function automatic logic [80:0] model(logic [63:0] w);
    logic [80:0] o;
    int ord[8];
    int n1, s;
    bit rare[8];
    n1 = 0;
    for (int i = 0; i < 8; i++) begin
      rare[i] = m_n3(w[63-8*i -: 8]) >= 3;
      if (rare[i]) n1++;
    end
    s = 0;
    for (int i = 0; i < 8; i++) if (rare[i]) begin ord[s] = i; s++; end
    for (int i = 0; i < 8; i++) if (!rare[i]) begin ord[s] = i; s++; end
    o = '0;
    o[80] = (n1 > 0);
    for (int sl = 0; sl < 8; sl++) begin
      bit nx;
      nx = (sl < n1 - 1) || (n1 == 8);
      o[79-10*sl -: 10] = m_enc(w[63-8*ord[sl] -: 8], ord[sl], nx);
    end
    return o;
  endfunction

  task automatic chk(bit ok, string req, logic [80:0] act, logic [80:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [63:0] w, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    exp_q.push_back(model(w));
    tag_q.push_back(tag);
    stamp_q.push_back(pcnt + 4);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 spurious", out_data, '0);
      end else begin
        logic [80:0] e;
        string tg;
        int st;
        bit d3;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        st = stamp_q.pop_front();
        chk(out_data[79:0] == e[79:0], {tg, " R5 codes"}, out_data, e);
        chk(out_data[80] == e[80], "R7 aux", {80'b0, out_data[80]}, {80'b0, e[80]});
        chk(pcnt == st, "R9 latency", 81'(pcnt), 81'(st));
        d3 = 1'b0;
        for (int j = 0; j < 40; j++) d3 = d3 | (out_data[2*j+:2] == 2'b11);
        chk(!d3, "R10 digit", out_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] x;
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid, "R11 reset", {79'b0, in_ready, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R11 ready", {80'b0, in_ready}, 81'd1);

    send(64'h0, "R2");
    send(64'h00_01_02_04_05_06_08_09, "R8");
    idle(2);
    send(64'h03_0F_C0_3C_30_0C_F0_33, "R3");
    send(64'h0F_3F_0F_0F_0F_0F_0F_0F, "R1");
    send(64'hFF_FF_FF_FF_FF_FF_FF_FF, "R6 allrare");
    send(64'hFF_FC_F3_CF_3F_FD_FE_7F, "R4");
    send(64'h00_FF_11_3F_22_FC_44_FE, "R5");
    send(64'h12_34_56_01_02_20_10_FF, "R6 tail");
    idle(3);

    x = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 200; n++) begin
      logic [63:0] a, b;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      a = x;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      b = x;
      send((n % 3 == 0) ? a : (a | b), "R9 stream");
      if (n % 37 == 36) idle(2);
    end
    idle(10);
    chk(exp_q.size() == 0, "R9 drained", 81'(exp_q.size()), '0);
    finish_run();
  end

endmodule